// File: doc/BRIEF.md
# Prescaled Down-Counting Event Timer

This block holds two countdown channels for timekeeping and wake-up events. Each channel picks one of four prescaled tick inputs (nominally 32.768 kHz, 1.024 kHz, 32 Hz and 8 MHz), all supplied as single-cycle strobes in the fast clock domain. Each channel also has a 24-bit reload count and a control word with enable and restart bits. Counting begins when enable goes from 0 to 1, not when the count is written. That edge copies the reload count and the source choice into the working state. When a one-shot channel reaches zero, it stops, pulses its interrupt line for one cycle and sets a sticky status bit that software clears by writing 1 to it.

Channel 0 can also run as a 32-bit free-running counter. In that mode the upper eight bits of its start value come from channel 1's reload register. The counter wraps from zero to all-ones and pulses its interrupt each time it reaches zero. Its observation register reads the bitwise complement of the count, so software sees a value that rises. Software reaches the block through a simple word-wide write and read port.

Top module: `edt_timer`

## Requirements
- R1: After reset, every register reads 0, no channel runs and both interrupt lines are low. Reads are registered: data for a read accepted at one clock edge appears at `rdata` after that edge and is held until the next read.
- R2: Map: channel c has control at 4c+0 (bit 0 enable, bit 1 restart, bit 2 chain), source at 4c+1 (bits 1:0 index `tick_i`), reload count at 4c+2 (bits 23:0) and observation at 4c+3. When enable goes from 0 to 1, the channel copies its reload count and source into its working state. After that, each strobe of the chosen source lowers the count by one.
- R3: Strobes on sources other than the one latched at start leave the count unchanged.
- R4: A one-shot channel whose count reaches zero stops at 0. It drives `irq_o[c]` high for exactly one cycle, in the cycle after the edge where the last strobe was taken. Further strobes have no effect.
- R5: The status register is at address 8, with bit c for channel c. Bit c is set in the cycle after the interrupt pulse and stays set until software writes 1 to it; writing 0 leaves it unchanged.
- R6: Writing enable = 0 freezes the count and ignores further strobes. Setting enable again reloads the count.
- R7: Writing enable = 1 while the channel is already enabled, without restart, reloads nothing. Changes to source or count made while the channel runs take effect only at the next start.
- R8: Writing enable and restart together reloads the count and source even while the channel is enabled. The restart bit always reads 0.
- R9: A start with a zero start value does not run the channel, and the count held before it is kept.
- R10: Chained start on channel 0 (enable with bit 2) loads {channel 1 count bits 7:0, channel 0 count} as a 32-bit value. The counter keeps running, pulses `irq_o[0]` on reaching zero, wraps to 0xFFFFFFFF, and its observation register reads the bitwise NOT of the count.
- R11: Channel 1 ignores the chain bit: it runs one-shot, reads back bit 2 as 0, and its observation register shows the plain count.
- R12: The channels count independently from their own latched sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_i | input | 4 | Prescaled tick strobes, one per source |
| irq_o | output | 2 | One-cycle expiry pulse per channel |

## Verification
The assertions assume that each tick input is a clean single-cycle strobe in the fast clock domain, that write and read strobes never carry X, and that the address does not change during a write. The stimulus drives every input half a cycle away from the active edge. It pulses one tick for one cycle and then leaves a quiet cycle, and it never issues a write and a read in the same cycle. A behavioural cycle model in the bench predicts the interrupt lines and read data on every clock. This keeps the comparison valid while strobes, restarts and chain starts interleave.

// File: rtl/edt_pkg.sv
package edt_pkg;
  // register slots inside one channel window
  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_SRC  = 2'd1,
    OFS_LOAD = 2'd2,
    OFS_OBS  = 2'd3
  } ofs_e;

  localparam int CH_SPAN   = 4;  // words per channel window
  localparam int STAT_WORD = 8;  // status word address
  localparam int B_EN      = 0;
  localparam int B_RESTART = 1;
  localparam int B_CHAIN   = 2;
endpackage

// File: rtl/edt_tick_pick.sv
module edt_tick_pick #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             stb_o
);
  always_comb begin
    stb_o = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel_i == SEL_W'(k)) stb_o = tick_i[k];
    end
  end
endmodule

// File: rtl/edt_chan.sv
module edt_chan #(
  parameter int W     = 32,
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             chain_i,
  input  logic [W-1:0]     load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] tick_i,
  output logic [W-1:0]     cnt_o,
  output logic             chain_o,
  output logic             irq_o
);
  logic [W-1:0]     cnt_q;
  logic [SEL_W-1:0] act_sel_q;
  logic             run_q, chain_q, irq_q, stb;

  edt_tick_pick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_pick (
    .tick_i (tick_i),
    .sel_i  (act_sel_q),
    .stb_o  (stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      act_sel_q <= '0;
      run_q     <= 1'b0;
      chain_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start_i) begin
        if (load_i != '0) begin
          cnt_q     <= load_i;
          act_sel_q <= sel_i;
          chain_q   <= chain_i;
          run_q     <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end else if (stop_i) begin
        run_q <= 1'b0;
      end else if (run_q && stb) begin
        cnt_q <= cnt_q - W'(1);
        if (cnt_q == W'(1)) begin
          irq_q <= 1'b1;
          if (!chain_q) run_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign chain_o = chain_q;
  assign irq_o   = irq_q;

  // R6
  idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> $stable(cnt_q));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && stb && !start_i && !stop_i) |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R9
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && load_i == '0) |=> !run_q);
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !chain_q) |-> (!run_q && cnt_q == '0));
endmodule

// File: rtl/edt_regs.sv
module edt_regs
  import edt_pkg::*;
#(
  parameter int CH_W   = 24,
  parameter int CAS_W  = 32,
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 4,
  parameter int N_CH   = 2,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CAS_W-1:0]              wdata,
  output logic [CAS_W-1:0]              rdata,
  output logic [N_CH-1:0]               start_o,
  output logic [N_CH-1:0]               stop_o,
  output logic                          chain_o,
  output logic [N_CH-1:0][SEL_W-1:0]    src_o,
  output logic [N_CH-1:0][CAS_W-1:0]    load_o,
  input  logic [N_CH-1:0][CAS_W-1:0]    cnt_i,
  input  logic                          chain_act_i,
  input  logic [N_CH-1:0]               irq_i
);
  localparam int HI_W = CAS_W - CH_W;

  logic [N_CH-1:0]            en_v;
  logic [N_CH-1:0][CH_W-1:0]  load_v;
  logic [N_CH-1:0]            stat_q;
  logic                       chain_q;
  logic                       stat_hit;
  logic [CAS_W-1:0]           rd_nxt;

  assign stat_hit = wr_en && (addr == ADDR_W'(STAT_WORD));
  assign chain_o  = wdata[B_CHAIN];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             en_r;
    logic [SEL_W-1:0] src_r;
    logic [CH_W-1:0]  load_r;
    logic             hit_ctrl, hit_src, hit_load;

    assign hit_ctrl = wr_en && (addr == ADDR_W'(c * CH_SPAN + int'(OFS_CTRL)));
    assign hit_src  = wr_en && (addr == ADDR_W'(c * CH_SPAN + int'(OFS_SRC)));
    assign hit_load = wr_en && (addr == ADDR_W'(c * CH_SPAN + int'(OFS_LOAD)));

    assign start_o[c] = hit_ctrl && wdata[B_EN] && (!en_r || wdata[B_RESTART]);
    assign stop_o[c]  = hit_ctrl && !wdata[B_EN] && en_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r   <= 1'b0;
        src_r  <= '0;
        load_r <= '0;
      end else begin
        if (hit_ctrl) en_r   <= wdata[B_EN];
        if (hit_src)  src_r  <= wdata[SEL_W-1:0];
        if (hit_load) load_r <= wdata[CH_W-1:0];
      end
    end

    assign en_v[c]   = en_r;
    assign src_o[c]  = src_r;
    assign load_v[c] = load_r;

    if (c == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           chain_q <= 1'b0;
        else if (hit_ctrl) chain_q <= wdata[B_CHAIN];
      end
      assign load_o[c] = wdata[B_CHAIN] ? {load_v[1][HI_W-1:0], load_r}
                                        : CAS_W'(load_r);
    end else begin : g_tail
      assign load_o[c] = CAS_W'(load_r);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~(stat_hit ? wdata[N_CH-1:0] : '0)) | irq_i;
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == ADDR_W'(STAT_WORD)) begin
      rd_nxt[N_CH-1:0] = stat_q;
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr[ADDR_W-1:2] == (ADDR_W-2)'(c)) begin
          case (ofs_e'(addr[1:0]))
            OFS_CTRL: begin
              rd_nxt[B_EN]    = en_v[c];
              rd_nxt[B_CHAIN] = (c == 0) ? chain_q : 1'b0;
            end
            OFS_SRC:  rd_nxt[SEL_W-1:0] = src_o[c];
            OFS_LOAD: rd_nxt[CH_W-1:0]  = load_v[c];
            default:  rd_nxt = (c == 0 && chain_act_i) ? ~cnt_i[c] : cnt_i[c];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end

  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_hit && wdata[0] && !irq_i[0]) |=> !stat_q[0]);
  // R5
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !(stat_hit && wdata[0])) |=> stat_q[0]);
  // R4
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq_i[1] |=> stat_q[1]);
endmodule

// File: rtl/edt_timer.sv
module edt_timer #(
  parameter int CH_W   = 24,
  parameter int CAS_W  = 32,
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CAS_W-1:0]  wdata,
  output logic [CAS_W-1:0]  rdata,
  input  logic [N_SRC-1:0]  tick_i,
  output logic [1:0]        irq_o
);
  localparam int N_CH  = 2;
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_CH-1:0]             start, stop, irq, chain_act;
  logic                        chain_req;
  logic [N_CH-1:0][SEL_W-1:0]  src;
  logic [N_CH-1:0][CAS_W-1:0]  load, cnt;

  edt_regs #(
    .CH_W(CH_W), .CAS_W(CAS_W), .N_SRC(N_SRC), .ADDR_W(ADDR_W),
    .N_CH(N_CH), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .start_o(start), .stop_o(stop),
    .chain_o(chain_req), .src_o(src), .load_o(load), .cnt_i(cnt),
    .chain_act_i(chain_act[0]), .irq_i(irq)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    edt_chan #(.W(CAS_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst(rst), .start_i(start[c]), .stop_i(stop[c]),
      .chain_i((c == 0) ? chain_req : 1'b0),
      .load_i(load[c]), .sel_i(src[c]), .tick_i(tick_i),
      .cnt_o(cnt[c]), .chain_o(chain_act[c]), .irq_o(irq[c])
    );
  end

  assign irq_o = irq;

  // R11
  tail_no_chain_chk: assert property (@(posedge clk) disable iff (rst)
    !chain_act[1]);
endmodule

// File: tb/edt_timer_bench.sv
module edt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  tick = '0;
  logic [1:0]  irq_o;

  int n_run = 0, n_fail = 0;
  int irq_cnt0 = 0, irq_cnt1 = 0;
  bit live = 0, done = 0;

  always #10 clk = ~clk;

  edt_timer u_edt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_i(tick), .irq_o(irq_o)
  );

  // behavioural cycle model
  logic [31:0] m_cnt[2];
  logic [23:0] m_load[2];
  logic [1:0]  m_src[2], m_act[2];
  logic        m_en[2], m_run[2], m_chn[2], m_stat[2], m_irq[2];
  logic        m_chain_bit;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] v = '0;
    if (a == 4'd8) v = {30'd0, m_stat[1], m_stat[0]};
    else if (a[3:2] < 2) begin
      case (a[1:0])
        2'd0: v = {29'd0, (a[3:2] == 0) ? m_chain_bit : 1'b0, 1'b0, m_en[a[2]]};
        2'd1: v = {30'd0, m_src[a[2]]};
        2'd2: v = {8'd0, m_load[a[2]]};
        default: v = (a[3:2] == 0 && m_chn[0]) ? ~m_cnt[0] : m_cnt[a[2]];
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_load[c] = 0; m_src[c] = 0; m_act[c] = 0;
        m_en[c] = 0; m_run[c] = 0; m_chn[c] = 0; m_stat[c] = 0; m_irq[c] = 0;
      end
      m_chain_bit = 0; m_rd = 0;
    end else begin
      logic nirq[2];
      if (rd_en) m_rd = model_read(addr);
      for (int c = 0; c < 2; c++) begin
        logic hit;
        logic [31:0] lv;
        hit = wr_en && addr == 4'(c * 4);
        nirq[c] = 0;
        if (hit && wdata[0] && (!m_en[c] || wdata[1])) begin
          lv = (c == 0 && wdata[2]) ? {m_load[1][7:0], m_load[0]} : {8'd0, m_load[c]};
          if (lv != 0) begin
            m_cnt[c] = lv; m_run[c] = 1; m_act[c] = m_src[c];
            m_chn[c] = (c == 0) && wdata[2];
          end else m_run[c] = 0;
        end else if (hit && !wdata[0] && m_en[c]) m_run[c] = 0;
        else if (m_run[c] && tick[m_act[c]]) begin
          if (m_cnt[c] == 1) begin
            nirq[c] = 1;
            if (!m_chn[c]) m_run[c] = 0;
          end
          m_cnt[c] = m_cnt[c] - 1;
        end
        if (wr_en && addr == 4'd8 && wdata[c]) m_stat[c] = 0;
        if (m_irq[c]) m_stat[c] = 1;
        m_irq[c] = nirq[c];
        if (hit) m_en[c] = wdata[0];
        if (hit && c == 0) m_chain_bit = wdata[2];
        if (wr_en && addr == 4'(c * 4 + 1)) m_src[c] = wdata[1:0];
        if (wr_en && addr == 4'(c * 4 + 2)) m_load[c] = wdata[23:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R4 irq_o vs model", {30'd0, irq_o}, {30'd0, m_irq[1], m_irq[0]});
      chk("R2 rdata vs model", rdata, m_rd);
      if (irq_o[0]) irq_cnt0++;
      if (irq_o[1]) irq_cnt1++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic tk(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0; live = 1;
    rd(4'd3, 0, "R1 reset OBS0");
    rd(4'd8, 0, "R1 reset status");
    rd(4'd0, 0, "R1 reset CTRL0");
    // one-shot on source 2
    wr(4'd1, 2); wr(4'd2, 5); wr(4'd0, 1);
    tk(4'b0001, 3);
    rd(4'd3, 5, "R3 other source ignored");
    tk(4'b0100, 3);
    rd(4'd3, 2, "R2 counts selected source");
    tk(4'b0100, 2);
    rd(4'd3, 0, "R4 reaches zero");
    chk("R4 single irq pulse", irq_cnt0, 1);
    rd(4'd8, 1, "R5 status set");
    tk(4'b0100, 2);
    rd(4'd3, 0, "R4 stays stopped");
    wr(4'd8, 0);
    rd(4'd8, 1, "R5 write 0 keeps status");
    wr(4'd8, 1);
    rd(4'd8, 0, "R5 write 1 clears status");
    // enable held high
    wr(4'd0, 1);
    rd(4'd3, 0, "R7 re-enable without restart");
    wr(4'd2, 9); wr(4'd1, 1); wr(4'd0, 1);
    rd(4'd3, 0, "R7 no reload while enabled");
    wr(4'd0, 3);
    rd(4'd3, 9, "R8 restart reloads");
    tk(4'b0010, 2); tk(4'b0100, 1);
    rd(4'd3, 7, "R8 restart latched new source");
    rd(4'd0, 1, "R8 restart bit reads 0");
    // disable
    wr(4'd0, 0);
    tk(4'b0010, 2);
    rd(4'd3, 7, "R6 frozen when disabled");
    wr(4'd0, 1);
    rd(4'd3, 9, "R6 re-enable reloads");
    wr(4'd1, 3);
    tk(4'b1000, 1); tk(4'b0010, 1);
    rd(4'd3, 8, "R7 source change deferred");
    // zero start
    wr(4'd0, 0); wr(4'd2, 0); wr(4'd0, 1);
    tk(4'b1010, 2);
    rd(4'd3, 8, "R9 zero load does not start");
    rd(4'd8, 0, "R9 no expiry");
    // chained free-run
    wr(4'd2, 2); wr(4'd1, 0); wr(4'd0, 0); wr(4'd0, 5);
    rd(4'd3, 32'hFFFF_FFFD, "R10 inverted observation");
    tk(4'b0001, 2);
    rd(4'd3, 32'hFFFF_FFFF, "R10 reaches zero");
    chk("R10 irq at zero", irq_cnt0, 2);
    tk(4'b0001, 1);
    rd(4'd3, 32'h0000_0000, "R10 wraps to all-ones");
    rd(4'd0, 5, "R10 chain bit readback");
    wr(4'd8, 1);
    wr(4'd6, 32'h12); wr(4'd2, 32'h34_5678); wr(4'd0, 7);
    rd(4'd3, 32'hEDCB_A987, "R10 upper bits from channel 1");
    wr(4'd6, 32'hFF); wr(4'd2, 32'hFF_FFFF); wr(4'd0, 7);
    rd(4'd3, 0, "R10 start at all-ones");
    tk(4'b0001, 1);
    rd(4'd3, 1, "R10 counts up as seen");
    // channel 1 alongside
    wr(4'd6, 3); wr(4'd5, 0); wr(4'd4, 5);
    tk(4'b0001, 3);
    rd(4'd7, 0, "R11 channel 1 one-shot plain count");
    rd(4'd8, 2, "R11 channel 1 status");
    chk("R11 channel 1 irq pulse", irq_cnt1, 1);
    tk(4'b0001, 1);
    rd(4'd7, 0, "R11 channel 1 stopped, no wrap");
    rd(4'd3, 5, "R12 channel 0 independent");
    rd(4'd4, 1, "R11 chain bit ignored");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule